// File: doc/BRIEF.md
# Per-Register Queue Rename Unit

This block renames destination registers without a shared free list or a map table. Each architectural register has its own small circular queue of physical slots, with a head counter and a tail counter. A physical tag is the architectural index with the slot index appended. Renaming a destination advances that register's tail and hands out the new slot. A source operand reads the slot its register's tail currently points at. Committing an instruction advances the head of its destination register.

When a branch is renamed, the block copies every tail counter into a checkpoint entry and reports the entry number. A correct branch resolution releases that entry. A misprediction loads every tail counter in parallel from the entry. It also releases that entry and every entry allocated after it. Head counters are never restored; they keep following commit. The rename stage stalls when the destination queue is full, when no checkpoint entry can be taken for a branch, or while a recovery happens.

Top module: `rnq_rename_top`

## Requirements
- R1: After reset every head and tail counter is zero, every checkpoint entry is free, the allocation pointer is entry 0 and `ren_stall` is low, so every source tag reads slot 0.
- R2: An accepted non-branch rename returns `ren_dst_tag` = {dst index in bits [4:2], slot in bits [1:0]}. The slot is the register's tail plus one, modulo 4, and the tail takes that value at the next clock edge.
- R3: Each source tag is {src index, current tail of src}. The value is read before any increment made by the destination in the same cycle.
- R4: A non-branch rename stalls when the destination head equals its tail plus one, modulo 4. A stalled rename leaves every tail unchanged. `ren_stall` is low whenever `ren_valid` is low.
- R5: A commit increments the head of `commit_dst` by one and leaves every tail unchanged. When a commit and a rename name the same register in one cycle, the full check uses the head value from before the commit.
- R6: An accepted branch rename changes no tail and stores every tail in the entry at the allocation pointer. It reports that entry on `ren_ckpt_id`, and the pointer then advances circularly.
- R7: A branch rename stalls when the entry at the allocation pointer is in use.
- R8: A resolution with `br_mispredict` low releases the named entry if that entry is in use.
- R9: A misprediction on an in-use entry reloads every tail from that entry. Heads keep their values. The entry and every younger entry are released, and the allocation pointer returns to that entry.
- R10: A rename presented in the same cycle as a valid misprediction is stalled.
- R11: A resolution that names a free entry is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ren_valid | input | 1 | A rename request is present |
| ren_is_branch | input | 1 | The request is a branch (no destination, takes a checkpoint) |
| ren_dst | input | 3 | Destination architectural register |
| ren_src0 | input | 3 | First source architectural register |
| ren_src1 | input | 3 | Second source architectural register |
| ren_stall | output | 1 | Request not accepted this cycle |
| ren_dst_tag | output | 5 | Physical tag for the destination |
| ren_src0_tag | output | 5 | Physical tag for the first source |
| ren_src1_tag | output | 5 | Physical tag for the second source |
| ren_ckpt_id | output | 2 | Checkpoint entry a branch receives |
| commit_valid | input | 1 | An instruction commits |
| commit_dst | input | 3 | Destination register of the committing instruction |
| br_res_valid | input | 1 | A branch resolves |
| br_res_id | input | 2 | Checkpoint entry of the resolving branch |
| br_mispredict | input | 1 | The resolving branch was mispredicted |

## Verification
Commit and rename can act on the same register in one cycle, and the full check must use the head from before the commit. The bench fills one register's queue, then commits and renames that register together. It expects a stall in that cycle and acceptance in the next. A misprediction can also coincide with a rename. That rename must stall, and the tails must come back from the snapshot, which the bench reads through the source tags in the following cycle. A long pseudo-random phase mixes all four functions against a reference model in the scoreboard.

// File: rtl/rnq_pkg.sv
package rnq_pkg;

    localparam int unsigned DEF_ARCH  = 8;
    localparam int unsigned DEF_DEPTH = 4;
    localparam int unsigned DEF_CKPT  = 4;

    // why the rename port refuses a request this cycle
    typedef enum logic [1:0] {
        STALL_NONE    = 2'd0,
        STALL_FULL    = 2'd1,
        STALL_CKPT    = 2'd2,
        STALL_RECOVER = 2'd3
    } stall_cause_e;

endpackage

// File: rtl/rnq_ctr.sv
module rnq_ctr #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] val
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val = st_q.cnt;

endmodule

// File: rtl/rnq_ptr_bank.sv
module rnq_ptr_bank #(
    parameter int unsigned NUM_ARCH = 8,
    parameter int unsigned PW       = 2,
    localparam int unsigned AW      = $clog2(NUM_ARCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     head_inc,
    input  logic [AW-1:0]            head_idx,
    input  logic                     tail_inc,
    input  logic [AW-1:0]            tail_idx,
    input  logic                     tail_load,
    input  logic [NUM_ARCH*PW-1:0]   tail_load_val,
    output logic [NUM_ARCH*PW-1:0]   heads,
    output logic [NUM_ARCH*PW-1:0]   tails
);

    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_reg
        logic hit_head;
        logic hit_tail;

        assign hit_head = head_inc && (head_idx == AW'(g));
        assign hit_tail = tail_inc && (tail_idx == AW'(g));

        // head: count only, never reloaded
        rnq_ctr #(.W(PW)) u_head (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (hit_head),
            .load     (1'b0),
            .load_val ({PW{1'b0}}),
            .val      (heads[g*PW +: PW])
        );

        // tail: count on rename, parallel load on recovery
        rnq_ctr #(.W(PW)) u_tail (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (hit_tail),
            .load     (tail_load),
            .load_val (tail_load_val[g*PW +: PW]),
            .val      (tails[g*PW +: PW])
        );
    end

endmodule

// File: rtl/rnq_ckpt_store.sv
module rnq_ckpt_store #(
    parameter int unsigned NUM_ARCH = 8,
    parameter int unsigned PW       = 2,
    parameter int unsigned NUM_CKPT = 4,
    localparam int unsigned CW      = $clog2(NUM_CKPT),
    localparam int unsigned SW      = NUM_ARCH * PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [SW-1:0] cur_tails,
    input  logic          res_valid,
    input  logic [CW-1:0] res_id,
    input  logic          res_miss,
    output logic          avail,
    output logic [CW-1:0] alloc_id,
    output logic          restore,
    output logic [SW-1:0] restore_tails
);

    typedef struct packed {
        logic [NUM_CKPT-1:0]         busy;
        logic [CW-1:0]               aptr;
        logic [NUM_CKPT-1:0][SW-1:0] snap;
    } ck_st_t;

    ck_st_t st_d, st_q;

    logic          stop_walk;
    logic [CW-1:0] walk_idx;

    assign restore       = res_valid && res_miss && st_q.busy[res_id];
    assign restore_tails = st_q.snap[res_id];
    assign avail         = !st_q.busy[st_q.aptr];
    assign alloc_id      = st_q.aptr;

    always_comb begin
        st_d      = st_q;
        stop_walk = 1'b0;
        walk_idx  = res_id;
        if (restore) begin
            // release the entry and every younger one up to the allocation pointer
            for (int k = 0; k < int'(NUM_CKPT); k++) begin
                walk_idx = res_id + CW'(k);
                if (k != 0 && walk_idx == st_q.aptr) begin
                    stop_walk = 1'b1;
                end
                if (!stop_walk) begin
                    st_d.busy[walk_idx] = 1'b0;
                end
            end
            st_d.aptr = res_id;
        end else begin
            if (res_valid && !res_miss && st_q.busy[res_id]) begin
                st_d.busy[res_id] = 1'b0;
            end
            if (take) begin
                st_d.busy[st_q.aptr] = 1'b1;
                st_d.snap[st_q.aptr] = cur_tails;
                st_d.aptr            = st_q.aptr + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rnq_rename_top.sv
module rnq_rename_top
    import rnq_pkg::*;
#(
    parameter int unsigned NUM_ARCH = DEF_ARCH,
    parameter int unsigned DEPTH    = DEF_DEPTH,
    parameter int unsigned NUM_CKPT = DEF_CKPT,
    localparam int unsigned AW      = $clog2(NUM_ARCH),
    localparam int unsigned PW      = $clog2(DEPTH),
    localparam int unsigned CW      = $clog2(NUM_CKPT),
    localparam int unsigned TW      = AW + PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic          ren_is_branch,
    input  logic [AW-1:0] ren_dst,
    input  logic [AW-1:0] ren_src0,
    input  logic [AW-1:0] ren_src1,
    output logic          ren_stall,
    output logic [TW-1:0] ren_dst_tag,
    output logic [TW-1:0] ren_src0_tag,
    output logic [TW-1:0] ren_src1_tag,
    output logic [CW-1:0] ren_ckpt_id,
    input  logic          commit_valid,
    input  logic [AW-1:0] commit_dst,
    input  logic          br_res_valid,
    input  logic [CW-1:0] br_res_id,
    input  logic          br_mispredict
);

    localparam int unsigned SW = NUM_ARCH * PW;

    function automatic logic [PW-1:0] pick(input logic [SW-1:0] flat, input logic [AW-1:0] idx);
        logic [PW-1:0] r;
        r = '0;
        for (int i = 0; i < int'(NUM_ARCH); i++) begin
            if (idx == AW'(i)) begin
                r = flat[i*PW +: PW];
            end
        end
        return r;
    endfunction

    logic [SW-1:0] heads_w;
    logic [SW-1:0] tails_w;
    logic [SW-1:0] restore_tails_w;
    logic          restore_w;
    logic          ck_avail;
    logic [CW-1:0] ck_alloc;

    logic [PW-1:0] dst_head;
    logic [PW-1:0] dst_tail;
    logic [PW-1:0] dst_next;
    logic          dst_full;
    logic          fire;
    logic          tail_step;
    logic          ck_take;
    stall_cause_e  cause;

    assign dst_head = pick(heads_w, ren_dst);
    assign dst_tail = pick(tails_w, ren_dst);
    assign dst_next = dst_tail + PW'(1);
    assign dst_full = (dst_head == dst_next);

    always_comb begin
        cause = STALL_NONE;
        if (ren_valid) begin
            if (restore_w) begin
                cause = STALL_RECOVER;
            end else if (ren_is_branch) begin
                if (!ck_avail) cause = STALL_CKPT;
            end else if (dst_full) begin
                cause = STALL_FULL;
            end
        end
    end

    assign fire      = ren_valid && (cause == STALL_NONE);
    assign tail_step = fire && !ren_is_branch;
    assign ck_take   = fire && ren_is_branch;

    assign ren_stall    = (cause != STALL_NONE);
    assign ren_dst_tag  = {ren_dst, dst_next};
    assign ren_src0_tag = {ren_src0, pick(tails_w, ren_src0)};
    assign ren_src1_tag = {ren_src1, pick(tails_w, ren_src1)};
    assign ren_ckpt_id  = ck_alloc;

    rnq_ptr_bank #(.NUM_ARCH(NUM_ARCH), .PW(PW)) u_ptrs (
        .clk           (clk),
        .rst_n         (rst_n),
        .head_inc      (commit_valid),
        .head_idx      (commit_dst),
        .tail_inc      (tail_step),
        .tail_idx      (ren_dst),
        .tail_load     (restore_w),
        .tail_load_val (restore_tails_w),
        .heads         (heads_w),
        .tails         (tails_w)
    );

    rnq_ckpt_store #(.NUM_ARCH(NUM_ARCH), .PW(PW), .NUM_CKPT(NUM_CKPT)) u_ckpt (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (ck_take),
        .cur_tails     (tails_w),
        .res_valid     (br_res_valid),
        .res_id        (br_res_id),
        .res_miss      (br_mispredict),
        .avail         (ck_avail),
        .alloc_id      (ck_alloc),
        .restore       (restore_w),
        .restore_tails (restore_tails_w)
    );

endmodule

// File: rtl/rnq_checker.sv
module rnq_checker #(
    parameter int unsigned NUM_ARCH = 8,
    parameter int unsigned PW       = 2,
    localparam int unsigned AW      = $clog2(NUM_ARCH),
    localparam int unsigned SW      = NUM_ARCH * PW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ren_valid,
    input logic          ren_is_branch,
    input logic [AW-1:0] ren_dst,
    input logic          ren_stall,
    input logic          commit_valid,
    input logic          restore,
    input logic [SW-1:0] heads,
    input logic [SW-1:0] tails,
    input logic [SW-1:0] restore_tails
);

    function automatic logic [PW-1:0] sel(input logic [SW-1:0] flat, input logic [AW-1:0] idx);
        logic [PW-1:0] r;
        r = '0;
        for (int i = 0; i < int'(NUM_ARCH); i++) begin
            if (idx == AW'(i)) r = flat[i*PW +: PW];
        end
        return r;
    endfunction

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_valid |-> !ren_stall);

    p_full_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && !ren_is_branch && sel(heads, ren_dst) == sel(tails, ren_dst) + PW'(1)) |-> ren_stall);

    p_stall_holds_tails_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_stall && !restore) |=> $stable(tails));

    p_tail_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && !ren_stall && !ren_is_branch)
        |=> sel(tails, $past(ren_dst)) == $past(sel(tails, ren_dst)) + PW'(1));

    p_commit_no_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !ren_valid && !restore) |=> $stable(tails));

    p_restore_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> tails == $past(restore_tails));

    p_restore_keeps_heads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !commit_valid) |=> $stable(heads));

    p_recover_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && restore) |-> ren_stall);

endmodule

bind rnq_rename_top rnq_checker #(.NUM_ARCH(NUM_ARCH), .PW(PW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ren_valid     (ren_valid),
    .ren_is_branch (ren_is_branch),
    .ren_dst       (ren_dst),
    .ren_stall     (ren_stall),
    .commit_valid  (commit_valid),
    .restore       (restore_w),
    .heads         (heads_w),
    .tails         (tails_w),
    .restore_tails (restore_tails_w)
);

// File: tb/sim_rnq_rename_top.sv
module sim_rnq_rename_top;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0, ren_is_branch = 1'b0;
    logic [2:0] ren_dst = '0, ren_src0 = '0, ren_src1 = '0;
    logic       ren_stall;
    logic [4:0] ren_dst_tag, ren_src0_tag, ren_src1_tag;
    logic [1:0] ren_ckpt_id;
    logic       commit_valid = 1'b0;
    logic [2:0] commit_dst = '0;
    logic       br_res_valid = 1'b0, br_mispredict = 1'b0;
    logic [1:0] br_res_id = '0;

    always #(CLK_P/2) clk = ~clk;

    rnq_rename_top u0 (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_is_branch(ren_is_branch),
        .ren_dst(ren_dst), .ren_src0(ren_src0), .ren_src1(ren_src1),
        .ren_stall(ren_stall), .ren_dst_tag(ren_dst_tag),
        .ren_src0_tag(ren_src0_tag), .ren_src1_tag(ren_src1_tag),
        .ren_ckpt_id(ren_ckpt_id),
        .commit_valid(commit_valid), .commit_dst(commit_dst),
        .br_res_valid(br_res_valid), .br_res_id(br_res_id),
        .br_mispredict(br_mispredict)
    );

    typedef struct {
        string      req;
        bit         stall;
        bit         chk_dst;
        logic [4:0] dtag;
        logic [4:0] s0;
        logic [4:0] s1;
        bit         chk_ck;
        logic [1:0] ck;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    // reference state
    bit [1:0] m_head [8];
    bit [1:0] m_tail [8];
    bit       m_busy [4];
    bit [1:0] m_aptr;
    bit [1:0] m_snap [4][8];

    task automatic cmp(input string req, input string what, input logic [4:0] act, input logic [4:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items and compares once outputs have settled
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.req, "stall", {4'd0, ren_stall}, {4'd0, e.stall});
                cmp(e.req, "src0 tag", ren_src0_tag, e.s0);
                cmp(e.req, "src1 tag", ren_src1_tag, e.s1);
                if (e.chk_dst) cmp(e.req, "dst tag", ren_dst_tag, e.dtag);
                if (e.chk_ck)  cmp(e.req, "ckpt id", {3'd0, ren_ckpt_id}, {3'd0, e.ck});
            end
        end
    end

    // driver: one cycle of stimulus, expected item from the model, then model update
    task automatic step(input string req, input bit v, input bit br, input bit [2:0] d,
                        input bit [2:0] s0, input bit [2:0] s1, input bit cv, input bit [2:0] cd,
                        input bit rv, input bit [1:0] rid, input bit rm);
        exp_t e;
        bit   misp, stall, acc;
        @(negedge clk);
        ren_valid = v; ren_is_branch = br; ren_dst = d; ren_src0 = s0; ren_src1 = s1;
        commit_valid = cv; commit_dst = cd;
        br_res_valid = rv; br_res_id = rid; br_mispredict = rm;

        misp  = rv && rm && m_busy[rid];
        stall = v && (misp || (br ? m_busy[m_aptr] : (m_head[d] == 2'(m_tail[d] + 1))));
        acc   = v && !stall;
        e.req     = req;
        e.stall   = stall;
        e.s0      = {s0, m_tail[s0]};
        e.s1      = {s1, m_tail[s1]};
        e.chk_dst = acc && !br;
        e.dtag    = {d, 2'(m_tail[d] + 1)};
        e.chk_ck  = acc && br;
        e.ck      = m_aptr;
        exp_q.push_back(e);

        if (cv) m_head[cd] = m_head[cd] + 1;
        if (misp) begin
            bit stop;
            stop = 0;
            for (int i = 0; i < 8; i++) m_tail[i] = m_snap[rid][i];
            for (int k = 0; k < 4; k++) begin
                bit [1:0] ix;
                ix = rid + 2'(k);
                if (k != 0 && ix == m_aptr) stop = 1;
                if (!stop) m_busy[ix] = 0;
            end
            m_aptr = rid;
        end else begin
            if (rv && !rm && m_busy[rid]) m_busy[rid] = 0;
            if (acc && !br) m_tail[d] = m_tail[d] + 1;
            if (acc && br) begin
                for (int i = 0; i < 8; i++) m_snap[m_aptr][i] = m_tail[i];
                m_busy[m_aptr] = 1;
                m_aptr = m_aptr + 1;
            end
        end
    endtask

    task automatic ren(input string req, input bit [2:0] d, input bit [2:0] s0, input bit [2:0] s1);
        step(req, 1, 0, d, s0, s1, 0, 0, 0, 0, 0);
    endtask

    task automatic brn(input string req);
        step(req, 1, 1, 0, 1, 2, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        bit [15:0] lfsr;
        for (int i = 0; i < 8; i++) begin m_head[i] = 0; m_tail[i] = 0; end
        for (int c = 0; c < 4; c++) m_busy[c] = 0;
        m_aptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset, all tails at slot 0
        step("R1", 0, 0, 0, 0, 5, 0, 0, 0, 0, 0);
        step("R1", 0, 0, 0, 7, 3, 0, 0, 0, 0, 0);

        // R2: three renames of r1 hand out slots 1,2,3
        ren("R2", 1, 1, 0);
        ren("R2", 1, 1, 0);
        ren("R2", 1, 1, 0);
        // R4: fourth rename finds the queue full
        ren("R4", 1, 1, 0);
        step("R4", 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
        // R5: commit and rename of r1 together still stall on the old head
        step("R5", 1, 0, 1, 1, 0, 1, 1, 0, 0, 0);
        ren("R5", 1, 1, 0);
        // R3: source of the same register sees the tail before the increment
        ren("R3", 2, 2, 2);
        step("R3", 0, 0, 0, 2, 2, 0, 0, 0, 0, 0);
        // R5: commit alone leaves the tails alone
        step("R5", 0, 0, 0, 3, 1, 1, 3, 0, 0, 0);
        step("R5", 0, 0, 0, 3, 1, 0, 0, 0, 0, 0);

        // R6: branch takes entry 0 and snapshots the tails
        brn("R6");
        ren("R6", 2, 2, 1);
        ren("R6", 2, 2, 1);
        // R10: rename in the recovery cycle is held off; R9 restore from entry 0
        step("R10", 1, 0, 4, 2, 1, 0, 0, 1, 0, 1);
        step("R9", 0, 0, 0, 2, 1, 0, 0, 0, 0, 0);
        // R11: misprediction on a free entry changes nothing
        step("R11", 1, 0, 4, 2, 4, 0, 0, 1, 2, 1);
        step("R11", 0, 0, 0, 2, 4, 0, 0, 0, 0, 0);

        // R7: four branches take entries 0..3, the fifth stalls
        brn("R6"); brn("R6"); brn("R6"); brn("R6");
        brn("R7");
        // R8: releasing entry 1 does not free the slot at the pointer; entry 0 does
        step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        brn("R8");
        step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        brn("R8");
        // R9: misprediction on entry 2 releases 2, 3 and the younger 0
        ren("R9", 5, 5, 1);
        step("R9", 0, 0, 0, 5, 1, 0, 0, 1, 2, 1);
        brn("R9");
        brn("R9");
        brn("R9");

        // mixed traffic against the model (R2 R3 R4 R5 R6 R9)
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            bit [15:0] r;
            for (int b = 0; b < 16; b++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r = lfsr;
            step("R4 mixed", r[1:0] != 0, r[4:2] == 0, r[7:5], r[10:8], r[13:11],
                 r[14], r[7:5] ^ 3'(r[15]), r[9:8] == 0 && r[15], r[12:11], r[3]);
        end
        step("R4", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        #(CLK_P/2);
        finish_run();
    end

endmodule